// File: doc/BRIEF.md
# CCD Clock Pattern Sequencer

This block produces the parallel clock levels that shift charge out of a CCD. A host loads a small program of pattern words while the block is idle. Each word sets the clock lines and how long they stay there. A start request first runs an exposure interval, during which the lines sit at a safe level. The block then plays the program from address 0 until it meets a halt word. End-of-group words repeat a row group and a frame group a programmed number of times. The frame group may enclose the row group.

One base cycle of the design clock is the time unit; at the intended 48 MHz it is about 20.8 ns. No state is shorter than seven base cycles. A 10-bit per-word extension adds base cycles one at a time. The exposure timer counts ticks of `TICK_DIV` base cycles, which is 25 µs at the default divider. An abort input drops the block back to idle at once.

Top module: `ccd_seq_top`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `lines_o` is all zeros (the safe level resets to zero).
- R2: A pattern word is 16 bits: bits 15:14 opcode, bits 13:4 extension E, bits 3:0 line levels. Once loaded, its line levels appear on `lines_o` for exactly 7+E consecutive cycles, with E from 0 to 1023.
- R3: Opcode 0 advances to the next address. Opcode 3 (halt) ends the run when its dwell finishes. In the cycle after that dwell, `done_o` is 1 for exactly one cycle, `busy_o` is 0, and `lines_o` equals the safe level.
- R4: Host write selector 3 sets the exposure count T from `host_wdata_i[27:0]`. After `start_i` is taken, `busy_o` is 1 and `lines_o` shows the safe level for T*TICK_DIV+1 cycles. Word 0 then appears. T=0 gives a single cycle.
- R5: Selector 1 sets the row group. Its start address comes from `host_addr_i` and its repeat count R from `host_wdata_i[9:0]`. When an opcode-1 word ends and the row group has run fewer than R+1 times, execution jumps to the row start. Otherwise it falls through and the count clears. R=1023 gives 1024 passes.
- R6: Selector 2 and opcode 2 do the same for the frame group. A row group nested inside a frame group runs its full count on every frame pass.
- R7: Host writes take effect only while idle: selector 0 writes the pattern word at `host_addr_i`, and selector 4 sets the safe level from `host_wdata_i[3:0]`. Writes and `start_i` made while `busy_o` is 1 are ignored.
- R8: When `abort_i` is sampled high, the next cycle shows `busy_o` 0, `done_o` 0 and `lines_o` at the safe level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 3 | Write target: 0 pattern, 1 row group, 2 frame group, 3 exposure, 4 safe level |
| host_addr_i | input | ADDR_W | Pattern address or group start address |
| host_wdata_i | input | 32 | Write data |
| start_i | input | 1 | Begin exposure then readout (idle only) |
| abort_i | input | 1 | Return to idle immediately |
| busy_o | output | 1 | Exposure or readout in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |
| lines_o | output | LINES | Clock line levels |

## Verification
When `start_i` is sampled at an edge, the safe level is due from the next falling edge on for T*TICK_DIV+1 samples. Word 0 appears right after. Each word then holds for 7+E samples, and the done pulse falls on the sample after the halt word's last one. An abort shows at the very next sample. The bench walks its own copy of the program with loop counters and compares every falling-edge sample against that schedule, so it catches any shift of one cycle. Writes and a second start are made during exposure, and a following run checks that neither left a trace.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  localparam int EXT_W = 10;
  localparam int OP_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NEXT  = 2'd0,
    OP_ROW   = 2'd1,
    OP_FRAME = 2'd2,
    OP_HALT  = 2'd3
  } pat_op_t;

  typedef enum logic [2:0] {
    SEL_PAT   = 3'd0,
    SEL_ROW   = 3'd1,
    SEL_FRAME = 3'd2,
    SEL_EXPO  = 3'd3,
    SEL_SAFE  = 3'd4
  } host_sel_t;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_EXPOSE = 2'd1,
    S_RUN    = 2'd2
  } seq_state_t;

endpackage

// File: rtl/ccd_pat_mem.sv
module ccd_pat_mem #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/ccd_loop_ctr.sv
module ccd_loop_ctr #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] rep_i,
  output logic             jump_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign jump_o = (cnt_q != rep_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (hit_i) begin
      cnt_d = jump_o ? cnt_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i || hit_i) begin
      cnt_q <= cnt_d;
    end
  end

  // R5/R6: pass count never runs past the programmed repeat value
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (cnt_q <= rep_i));

endmodule

// File: rtl/ccd_itimer.sv
module ccd_itimer #(
  parameter int DIV     = 1200,
  parameter int TIMER_W = 28,
  localparam int DIV_W  = $clog2(DIV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [TIMER_W-1:0] limit_i,
  output logic               reached_o
);

  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0]   div_q, div_d;
  logic [TIMER_W-1:0] tcnt_q, tcnt_d;
  logic               adv;

  assign reached_o = (tcnt_q == limit_i);
  assign adv       = en_i && !reached_o;

  always_comb begin
    div_d  = div_q;
    tcnt_d = tcnt_q;
    if (clr_i) begin
      div_d  = '0;
      tcnt_d = '0;
    end else if (adv) begin
      if (div_q == DIV_LAST) begin
        div_d  = '0;
        tcnt_d = tcnt_q + 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tcnt_q <= '0;
    end else if (clr_i || adv) begin
      div_q  <= div_d;
      tcnt_q <= tcnt_d;
    end
  end

  // R4: the exposure count stops at the programmed limit
  p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (tcnt_q <= limit_i));

  // R4: the tick counter only moves when a full divider period elapsed
  p_tick_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && div_q != DIV_LAST) |=> $stable(tcnt_q));

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
  import ccd_seq_pkg::*;
#(
  parameter int LINES     = 4,
  parameter int DEPTH     = 256,
  parameter int MIN_DWELL = 7,
  parameter int TICK_DIV  = 1200,
  parameter int ITIME_W   = 28,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int WORD_W   = LINES + EXT_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we_i,
  input  logic [2:0]        host_sel_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [31:0]       host_wdata_i,
  input  logic              start_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [LINES-1:0]  lines_o
);

  localparam int NGRP = 2;  // 0: row group, 1: frame group
  localparam logic [EXT_W:0] DWELL_BASE = (EXT_W+1)'(MIN_DWELL - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rstn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rstn     <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rstn     <= rst_meta;
    end
  end

  seq_state_t        st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d, nxt_pc, rd_addr;
  logic [WORD_W-1:0] cur_q, cur_d, rd_word;
  logic [EXT_W:0]    dcnt_q, dcnt_d, dwell_last;
  logic [LINES-1:0]  lines_q, lines_d, safe_q;
  logic              done_q, done_d;
  logic [ITIME_W-1:0] itime_q;
  logic [ADDR_W-1:0] grp_start_q [NGRP];
  logic [EXT_W-1:0]  grp_rep_q   [NGRP];
  logic [NGRP-1:0]   grp_hit, grp_jump;
  pat_op_t           cur_op;
  logic [EXT_W-1:0]  cur_ext;
  logic              idle, cfg_we, run_clr, dwell_end, expo_done;
  logic              unused_wdata;

  assign unused_wdata = ^host_wdata_i;

  assign idle    = (st_q == S_IDLE);
  assign cfg_we  = host_we_i && idle;
  assign run_clr = idle && start_i && !abort_i;

  assign cur_op     = pat_op_t'(cur_q[WORD_W-1 -: OP_W]);
  assign cur_ext    = cur_q[LINES +: EXT_W];
  assign dwell_last = DWELL_BASE + {1'b0, cur_ext};
  assign dwell_end  = (st_q == S_RUN) && (dcnt_q == dwell_last);

  assign grp_hit[0] = dwell_end && (cur_op == OP_ROW);
  assign grp_hit[1] = dwell_end && (cur_op == OP_FRAME);

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      itime_q <= '0;
      safe_q  <= '0;
    end else if (cfg_we) begin
      if (host_sel_i == SEL_EXPO) itime_q <= host_wdata_i[ITIME_W-1:0];
      if (host_sel_i == SEL_SAFE) safe_q  <= host_wdata_i[LINES-1:0];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam host_sel_t GSEL = (g == 0) ? SEL_ROW : SEL_FRAME;

    always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
        grp_start_q[g] <= '0;
        grp_rep_q[g]   <= '0;
      end else if (cfg_we && host_sel_i == GSEL) begin
        grp_start_q[g] <= host_addr_i;
        grp_rep_q[g]   <= host_wdata_i[EXT_W-1:0];
      end
    end

    ccd_loop_ctr #(.CNT_W(EXT_W)) i_loop (
      .clk      (clk),
      .rst_n    (rstn),
      .clr_i    (run_clr),
      .hit_i    (grp_hit[g]),
      .active_i (!idle),
      .rep_i    (grp_rep_q[g]),
      .jump_o   (grp_jump[g])
    );
  end

  // ---------------- pattern storage ----------------
  ccd_pat_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_mem (
    .clk     (clk),
    .we_i    (cfg_we && host_sel_i == SEL_PAT),
    .waddr_i (host_addr_i),
    .wdata_i (host_wdata_i[WORD_W-1:0]),
    .raddr_i (rd_addr),
    .rdata_o (rd_word)
  );

  // ---------------- exposure timer ----------------
  ccd_itimer #(.DIV(TICK_DIV), .TIMER_W(ITIME_W)) i_timer (
    .clk       (clk),
    .rst_n     (rstn),
    .clr_i     (run_clr),
    .en_i      (st_q == S_EXPOSE),
    .limit_i   (itime_q),
    .reached_o (expo_done)
  );

  // ---------------- address sequencing ----------------
  always_comb begin
    unique case (cur_op)
      OP_ROW:   nxt_pc = grp_jump[0] ? grp_start_q[0] : pc_q + 1'b1;
      OP_FRAME: nxt_pc = grp_jump[1] ? grp_start_q[1] : pc_q + 1'b1;
      OP_HALT:  nxt_pc = pc_q;
      default:  nxt_pc = pc_q + 1'b1;
    endcase
  end

  assign rd_addr = (st_q == S_RUN) ? nxt_pc : '0;

  // ---------------- next state ----------------
  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    cur_d   = cur_q;
    dcnt_d  = dcnt_q;
    lines_d = lines_q;
    done_d  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        lines_d = safe_q;
        if (run_clr) st_d = S_EXPOSE;
      end
      S_EXPOSE: begin
        lines_d = safe_q;
        if (abort_i) begin
          st_d = S_IDLE;
        end else if (expo_done) begin
          st_d    = S_RUN;
          pc_d    = '0;
          cur_d   = rd_word;
          dcnt_d  = '0;
          lines_d = rd_word[LINES-1:0];
        end
      end
      S_RUN: begin
        if (abort_i) begin
          st_d    = S_IDLE;
          lines_d = safe_q;
        end else if (dwell_end) begin
          if (cur_op == OP_HALT) begin
            st_d    = S_IDLE;
            done_d  = 1'b1;
            lines_d = safe_q;
          end else begin
            pc_d    = nxt_pc;
            cur_d   = rd_word;
            dcnt_d  = '0;
            lines_d = rd_word[LINES-1:0];
          end
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // ---------------- state registers ----------------
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      st_q    <= S_IDLE;
      pc_q    <= '0;
      cur_q   <= '0;
      dcnt_q  <= '0;
      lines_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      cur_q   <= cur_d;
      dcnt_q  <= dcnt_d;
      lines_q <= lines_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = !idle;
  assign done_o  = done_q;
  assign lines_o = lines_q;

  // ---------------- assertions ----------------
  // R2: lines stay put for the whole dwell of a word
  p_dwell_hold_r2: assert property (@(posedge clk) disable iff (!rstn)
    (st_q == S_RUN && dcnt_q != '0) |-> $stable(lines_o));

  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstn)
    done_o |=> !done_o);

  // R3: completion coincides with return to idle
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstn)
    done_o |-> !busy_o);

  // R7: exposure setting cannot change during a run
  p_busy_write_r7: assert property (@(posedge clk) disable iff (!rstn)
    (host_we_i && busy_o) |=> $stable(itime_q));

  // R8: abort leaves the block idle at the safe level
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstn)
    abort_i |=> (!busy_o && !done_o && lines_o == $past(safe_q)));

endmodule

// File: tb/test_ccd_seq_top.sv
module test_ccd_seq_top;

  localparam int LINES = 4;
  localparam int DEPTH = 64;
  localparam int DIV   = 4;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [2:0]    host_sel = '0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic          start = 1'b0;
  logic          abort = 1'b0;
  logic          busy, done;
  logic [LINES-1:0] lines;

  int checks = 0;
  int fails  = 0;

  // bench copy of the programmed state
  logic [15:0] mm [DEPTH];
  int rs, rr, fs, fr, itm;
  logic [3:0] sf;

  always #2 clk = ~clk;

  ccd_seq_top #(.LINES(LINES), .DEPTH(DEPTH), .TICK_DIV(DIV)) i_ccd_seq_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we_i    (host_we),
    .host_sel_i   (host_sel),
    .host_addr_i  (host_addr),
    .host_wdata_i (host_wdata),
    .start_i      (start),
    .abort_i      (abort),
    .busy_o       (busy),
    .done_o       (done),
    .lines_o      (lines)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkword(input int op, input int ext, input int lv);
    return {op[1:0], ext[9:0], lv[3:0]};
  endfunction

  task automatic host_wr(input int sel, input int addr, input int data);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel[2:0]; host_addr = addr[AW-1:0]; host_wdata = data;
    @(negedge clk);
    host_we = 1'b0;
    case (sel)
      0: mm[addr] = data[15:0];
      1: begin rs = addr; rr = data & 1023; end
      2: begin fs = addr; fr = data & 1023; end
      3: itm = data;
      4: sf = data[3:0];
      default: ;
    endcase
  endtask

  // Starts a run and checks every sample against the bench schedule.
  task automatic run(input string tag, input bit poke, input int abort_at);
    int pc, rc, fc, steps, cyc, dur, bad, last_lv;
    logic [15:0] w;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bad = 0;
    for (int k = 0; k <= itm * DIV; k++) begin
      if (lines !== sf || busy !== 1'b1) bad++;
      if (poke && k == 0) begin
        host_we = 1'b1; host_sel = 3'd3; host_wdata = itm + 5;
        start = 1'b1;
      end
      if (poke && k == 1) begin
        host_we = 1'b0; start = 1'b0;
        host_we = 1'b1; host_sel = 3'd0; host_addr = '0; host_wdata = 32'h0000_3ff5;
      end
      if (poke && k == 2) host_we = 1'b0;
      @(negedge clk);
    end
    host_we = 1'b0;
    chk(bad == 0, "R4", "exposure samples off", bad, 0);
    pc = 0; rc = 0; fc = 0; steps = 0; cyc = 0;
    forever begin
      w = mm[pc];
      dur = 7 + int'(w[13:4]);
      bad = 0; last_lv = 0;
      for (int d = 0; d < dur; d++) begin
        if (abort_at >= 0 && cyc == abort_at) begin
          abort = 1'b1;
          @(negedge clk);
          abort = 1'b0;
          chk(busy === 1'b0 && done === 1'b0 && lines === sf, "R8",
              "abort lines", int'(lines), int'(sf));
          return;
        end
        if (lines !== w[3:0] || busy !== 1'b1 || done !== 1'b0) begin
          bad++; last_lv = int'(lines);
        end
        @(negedge clk);
        cyc++;
      end
      chk(bad == 0, tag, $sformatf("word %0d dwell", pc), last_lv, int'(w[3:0]));
      steps++;
      if (steps > 20000) begin
        chk(1'b0, tag, "runaway program", steps, 20000);
        return;
      end
      case (w[15:14])
        2'd1: if (rc < rr) begin rc++; pc = rs; end else begin rc = 0; pc = (pc + 1) % DEPTH; end
        2'd2: if (fc < fr) begin fc++; pc = fs; end else begin fc = 0; pc = (pc + 1) % DEPTH; end
        2'd3: begin
          chk(done === 1'b1 && busy === 1'b0 && lines === sf, "R3",
              "halt completion", int'(done), 1);
          @(negedge clk);
          chk(done === 1'b0, "R3", "done width", int'(done), 0);
          return;
        end
        default: pc = (pc + 1) % DEPTH;
      endcase
    end
  endtask

  task automatic random_prog();
    int k;
    k = 1 + int'($urandom_range(3));
    host_wr(0, 0, mkword(0, $urandom_range(12), $urandom_range(15)));
    for (int a = 1; a <= k; a++)
      host_wr(0, a, mkword((a == k) ? 1 : 0, $urandom_range(12), $urandom_range(15)));
    host_wr(0, k + 1, mkword(2, $urandom_range(12), $urandom_range(15)));
    host_wr(0, k + 2, mkword(3, $urandom_range(12), $urandom_range(15)));
    host_wr(1, 1, $urandom_range(3));
    host_wr(2, 1, $urandom_range(3));
    host_wr(3, 0, $urandom_range(3));
    host_wr(4, 0, $urandom_range(15));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rs = 0; rr = 0; fs = 0; fr = 0; itm = 0; sf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done === 1'b0, "R1", "done after reset", int'(done), 0);
    chk(lines === 4'h0, "R1", "lines after reset", int'(lines), 0);

    // R2 R4: longest extension, zero exposure
    host_wr(4, 0, 4'h9);
    host_wr(3, 0, 0);
    host_wr(0, 0, mkword(0, 1023, 4'h5));
    host_wr(0, 1, mkword(0, 0, 4'h6));
    host_wr(0, 2, mkword(3, 1, 4'hA));
    run("R2", 1'b0, -1);

    // R5: row group at its full count
    host_wr(0, 0, mkword(0, 0, 4'h1));
    host_wr(0, 1, mkword(0, 0, 4'h2));
    host_wr(0, 2, mkword(1, 0, 4'h3));
    host_wr(0, 3, mkword(3, 0, 4'h4));
    host_wr(1, 1, 1023);
    host_wr(2, 0, 0);
    host_wr(3, 0, 2);
    run("R5", 1'b0, -1);

    // R6: nested groups with random contents and counts
    for (int n = 0; n < 6; n++) begin
      random_prog();
      run("R6", 1'b0, -1);
    end

    // R7: writes and start during a run are ignored; rerun checks old state
    host_wr(3, 0, 3);
    run("R7", 1'b1, -1);
    run("R7", 1'b0, -1);

    // R8: abort mid-readout, then a clean run
    run("R8", 1'b0, 9);
    @(negedge clk);
    chk(busy === 1'b0 && lines === sf, "R8", "idle after abort", int'(busy), 0);
    run("R6", 1'b0, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule